// File: doc/BRIEF.md
# Four-Channel Wiper Register Engine

This block holds the register state of four digitally controlled potentiometer channels and executes the commands that a serial front end has already decoded. Each channel has an 8-bit wiper register and four 8-bit data registers. In the wiper register, the low six bits give the tap position and the two upper bits carry a wiper-disable flag and a cascade flag. Per channel, the block drives a one-hot 64-tap select together with the two flags. The analog resistor array lies outside the block.

The front end presents the instruction byte and the data byte, when one is needed, with a single-cycle `cmd_valid` strobe. After an increment/decrement command it forwards up/down step pulses. The data registers stand in for nonvolatile cells: they reset to a fixed pattern derived from `INIT_SEED`, and every write to them holds `busy` for `WR_CYCLES` clock cycles. When reset is released, each wiper register copies its channel's data register 0 before any command is taken.

Top module: `wiper_bank`

## Requirements
- R1: While reset is asserted and for the first cycle after it, `busy` is 1. After that first edge, each channel c has its data register r equal to {2'b00, 6'(INIT_SEED + 16c + 4r)} and its wiper register equal to its data register 0.
- R2: Channel c drives tap_sel[64c +: 64] with exactly one bit set, at the index given by the wiper position. Position 00h sets bit 0 (low end) and 3Fh sets bit 63 (high end). wiper_off[c] mirrors wiper bit 6 and cascade[c] mirrors wiper bit 7.
- R3: Opcode 1010 loads the full data byte into the wiper register of channel cmd_instr[3:2], with position in bits 5:0, disable in bit 6 and cascade in bit 7. The outputs show the new value one cycle later.
- R4: Opcode 1001 (read wiper) and opcode 1011 (read data register cmd_instr[1:0]) pulse rd_valid for one cycle, one cycle after the strobe, with the value on rd_data. No other command pulses rd_valid.
- R5: Opcode 1100 writes the data byte into data register cmd_instr[1:0] of the selected channel and starts a busy window.
- R6: Opcode 1101 copies the selected data register into the channel's wiper register without busy. Opcode 1110 copies the wiper register into the selected data register and starts a busy window.
- R7: Opcode 0001 copies data register cmd_instr[1:0] into the wiper register of all four channels. Opcode 1000 copies every wiper register into data register cmd_instr[1:0] of its own channel and starts a busy window. Both ignore the channel field.
- R8: A busy window keeps `busy` at 1 for exactly WR_CYCLES cycles after the accepting edge. Commands and steps presented while busy change no register and produce no read data.
- R9: Opcode 0010 enters step mode on the selected channel. Each step pulse moves the position by one, up when step_up is 1 and down when it is 0. The position saturates at 3Fh and at 00h, and bits 7:6 are kept. The next accepted command ends step mode.
- R10: An opcode outside the nine above changes no state and raises err for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_instr | input | 8 | Opcode [7:4], channel [3:2], register [1:0] |
| cmd_data | input | 8 | Data byte for write commands |
| step_valid | input | 1 | Step pulse in step mode |
| step_up | input | 1 | Step direction, 1 = towards high end |
| busy | output | 1 | Power-up load or timed register write in progress |
| err | output | 1 | One-cycle undefined-opcode flag |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| tap_sel | output | 256 | One-hot tap select, 64 bits per channel |
| wiper_off | output | 4 | Per-channel wiper-disable flag |
| cascade | output | 4 | Per-channel cascade flag |

## Verification
Every command takes effect at the clock edge on which its strobe is seen. The tap selects, flags, rd_valid/rd_data and err are therefore due one cycle later. The bench drives at falling edges and samples at the next falling edge, which is the first point after that single register stage. Expected read values go into a queue and are compared by the monitor only when rd_valid appears. The busy window is measured by counting falling-edge samples with busy high, starting at the sample right after the accepting edge. For commands issued inside the window, the expected count is reduced by the cycles they use.

// File: rtl/wiper_bank.sv
module wiper_bank #(
  parameter int         WR_CYCLES = 24,
  parameter logic [5:0] INIT_SEED = 6'd5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [7:0]   cmd_instr,
  input  logic [7:0]   cmd_data,
  input  logic         step_valid,
  input  logic         step_up,
  output logic         busy,
  output logic         err,
  output logic         rd_valid,
  output logic [7:0]   rd_data,
  output logic [255:0] tap_sel,
  output logic [3:0]   wiper_off,
  output logic [3:0]   cascade
);
  localparam int NCH  = 4;
  localparam int NTAP = 64;
  localparam int CW   = $clog2(WR_CYCLES + 1);

  localparam logic [3:0] OP_RD_WIPER = 4'b1001;
  localparam logic [3:0] OP_WR_WIPER = 4'b1010;
  localparam logic [3:0] OP_RD_REG   = 4'b1011;
  localparam logic [3:0] OP_WR_REG   = 4'b1100;
  localparam logic [3:0] OP_REG2WIP  = 4'b1101;
  localparam logic [3:0] OP_WIP2REG  = 4'b1110;
  localparam logic [3:0] OP_GREG2WIP = 4'b0001;
  localparam logic [3:0] OP_GWIP2REG = 4'b1000;
  localparam logic [3:0] OP_STEP     = 4'b0010;

  logic [NCH-1:0][7:0]      wcr;
  logic [NCH-1:0][3:0][7:0] dr;
  logic [CW-1:0]            wr_cnt;
  logic                     boot;
  logic                     step_on;
  logic [1:0]               step_ch;

  wire [3:0] op = cmd_instr[7:4];
  wire [1:0] ch = cmd_instr[3:2];
  wire [1:0] rs = cmd_instr[1:0];

  assign busy = boot | (wr_cnt != '0);

  wire go     = cmd_valid & ~busy;
  wire nv_wr  = go & ((op == OP_WR_REG) | (op == OP_WIP2REG) | (op == OP_GWIP2REG));
  wire [5:0] step_pos = wcr[step_ch][5:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++)
        for (int r = 0; r < 4; r++)
          dr[c][r] <= {2'b00, INIT_SEED + 6'(c * 16 + r * 4)};
      wcr      <= '0;
      wr_cnt   <= '0;
      boot     <= 1'b1;
      step_on  <= 1'b0;
      step_ch  <= 2'd0;
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
      err      <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      err      <= 1'b0;
      if (nv_wr)
        wr_cnt <= CW'(WR_CYCLES);
      else if (wr_cnt != '0)
        wr_cnt <= wr_cnt - 1'b1;

      if (boot) begin
        boot <= 1'b0;
        for (int c = 0; c < NCH; c++) wcr[c] <= dr[c][0];
      end else if (go) begin
        step_on <= 1'b0;
        case (op)
          OP_RD_WIPER: begin rd_valid <= 1'b1; rd_data <= wcr[ch]; end
          OP_WR_WIPER: wcr[ch] <= cmd_data;
          OP_RD_REG:   begin rd_valid <= 1'b1; rd_data <= dr[ch][rs]; end
          OP_WR_REG:   dr[ch][rs] <= cmd_data;
          OP_REG2WIP:  wcr[ch] <= dr[ch][rs];
          OP_WIP2REG:  dr[ch][rs] <= wcr[ch];
          OP_GREG2WIP: for (int c = 0; c < NCH; c++) wcr[c] <= dr[c][rs];
          OP_GWIP2REG: for (int c = 0; c < NCH; c++) dr[c][rs] <= wcr[c];
          OP_STEP:     begin step_on <= 1'b1; step_ch <= ch; end
          default:     err <= 1'b1;
        endcase
      end else if (step_valid && step_on && !busy) begin
        if (step_up && step_pos != 6'h3F)
          wcr[step_ch][5:0] <= step_pos + 6'd1;
        else if (!step_up && step_pos != 6'h00)
          wcr[step_ch][5:0] <= step_pos - 6'd1;
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign tap_sel[c*NTAP +: NTAP] = NTAP'(1) << wcr[c][5:0];
    assign wiper_off[c] = wcr[c][6];
    assign cascade[c]   = wcr[c][7];
  end
endmodule

// File: rtl/wiper_bank_chk.sv
module wiper_bank_chk (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic [7:0]           cmd_instr,
  input logic                 busy,
  input logic                 err,
  input logic                 rd_valid,
  input logic [255:0]         tap_sel,
  input logic                 boot,
  input logic [3:0][7:0]      wcr,
  input logic [3:0][3:0][7:0] dr
);
  wire [3:0] op = cmd_instr[7:4];
  wire known = (op == 4'b1001) | (op == 4'b1010) | (op == 4'b1011) | (op == 4'b1100) |
               (op == 4'b1101) | (op == 4'b1110) | (op == 4'b0001) | (op == 4'b1000) |
               (op == 4'b0010);
  wire nvw = (op == 4'b1100) | (op == 4'b1110) | (op == 4'b1000);
  wire rdc = (op == 4'b1001) | (op == 4'b1011);

  for (genvar c = 0; c < 4; c++) begin : g_tap
    AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tap_sel[c*64 +: 64]) == 1); // R2
  end

  AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !boot |=> $stable(dr) && $stable(wcr)); // R8

  AST_NVW_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && nvw |=> busy); // R5

  AST_READ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_valid && !busy && rdc)); // R4

  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(cmd_valid && !busy && !known)); // R10

  AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $stable(dr) && $stable(wcr)); // R10
endmodule

bind wiper_bank wiper_bank_chk i_chk (.*);

// File: tb/test_wiper_bank.sv
module test_wiper_bank;
  localparam int CLK_PERIOD = 10;
  localparam int WRC = 24;
  localparam logic [5:0] SEED = 6'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, step_valid = 1'b0, step_up = 1'b0;
  logic [7:0] cmd_instr = 8'h00, cmd_data = 8'h00;
  logic busy, err, rd_valid;
  logic [7:0] rd_data;
  logic [255:0] tap_sel;
  logic [3:0] wiper_off, cascade;

  int checks = 0, errors = 0;
  logic [7:0] m_wcr [4];
  logic [7:0] m_dr [4][4];
  logic [7:0] exp_q [$];
  logic m_step_on = 1'b0;
  logic [1:0] m_step_ch = 2'd0;

  wiper_bank #(.WR_CYCLES(WRC), .INIT_SEED(SEED)) i_wiper_bank (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic check_taps(input string tag);
    for (int c = 0; c < 4; c++) begin
      chk(tag, tap_sel[c*64 +: 64], 64'(1) << m_wcr[c][5:0]);
      chk(tag, {62'd0, cascade[c], wiper_off[c]}, {62'd0, m_wcr[c][7], m_wcr[c][6]});
    end
  endtask

  task automatic issue(input logic [7:0] instr, input logic [7:0] data, input bit accept);
    logic [3:0] op; logic [1:0] c; logic [1:0] r;
    op = instr[7:4]; c = instr[3:2]; r = instr[1:0];
    @(negedge clk);
    cmd_instr = instr; cmd_data = data; cmd_valid = 1'b1;
    if (accept) begin
      m_step_on = 1'b0;
      case (op)
        4'b1001: exp_q.push_back(m_wcr[c]);
        4'b1010: m_wcr[c] = data;
        4'b1011: exp_q.push_back(m_dr[c][r]);
        4'b1100: m_dr[c][r] = data;
        4'b1101: m_wcr[c] = m_dr[c][r];
        4'b1110: m_dr[c][r] = m_wcr[c];
        4'b0001: for (int k = 0; k < 4; k++) m_wcr[k] = m_dr[k][r];
        4'b1000: for (int k = 0; k < 4; k++) m_dr[k][r] = m_wcr[k];
        4'b0010: begin m_step_on = 1'b1; m_step_ch = c; end
        default: ;
      endcase
    end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic step(input bit up);
    @(negedge clk);
    step_valid = 1'b1; step_up = up;
    if (m_step_on) begin
      if (up && m_wcr[m_step_ch][5:0] != 6'h3F) m_wcr[m_step_ch][5:0] += 6'd1;
      else if (!up && m_wcr[m_step_ch][5:0] != 6'h00) m_wcr[m_step_ch][5:0] -= 6'd1;
    end
    @(negedge clk);
    step_valid = 1'b0;
  endtask

  task automatic wait_idle(input int exp);
    int n = 0;
    while (busy === 1'b1 && n < 1000) begin n++; @(negedge clk); end
    chk("R8 busy window", n, exp);
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4 unexpected read actual=%0h expected=none", rd_data);
      end else chk("R4 read data", rd_data, exp_q.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) m_dr[c][r] = {2'b00, SEED + 6'(c * 16 + r * 4)};
    for (int c = 0; c < 4; c++) m_wcr[c] = m_dr[c][0];
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 1);
    chk("R1 no read in reset", rd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after load", busy, 0);
    check_taps("R1 wiper from reg0");

    for (int c = 0; c < 4; c++) issue({4'b1001, 2'(c), 2'b00}, 8'h00, 1);

    issue({4'b1010, 2'd1, 2'd0}, 8'h7F, 1);
    check_taps("R3 write wiper high end");
    issue({4'b1010, 2'd2, 2'd0}, 8'h80, 1);
    check_taps("R2 low end cascade");

    issue({4'b1011, 2'd3, 2'd2}, 8'h00, 1);

    issue({4'b1100, 2'd0, 2'd1}, 8'h2A, 1);
    wait_idle(WRC);
    issue({4'b1011, 2'd0, 2'd1}, 8'h00, 1);

    issue({4'b1101, 2'd0, 2'd1}, 8'h00, 1);
    chk("R6 no busy on reg to wiper", busy, 0);
    check_taps("R6 reg to wiper");
    issue({4'b1010, 2'd3, 2'd0}, 8'h11, 1);
    issue({4'b1110, 2'd3, 2'd3}, 8'h00, 1);
    wait_idle(WRC);
    issue({4'b1011, 2'd3, 2'd3}, 8'h00, 1);

    issue({4'b0001, 2'd3, 2'd1}, 8'h00, 1);
    check_taps("R7 global reg to wiper");
    issue({4'b1000, 2'd1, 2'd2}, 8'h00, 1);
    wait_idle(WRC);
    for (int c = 0; c < 4; c++) issue({4'b1011, 2'(c), 2'd2}, 8'h00, 1);

    issue({4'b1100, 2'd2, 2'd0}, 8'h33, 1);
    issue({4'b1010, 2'd2, 2'd0}, 8'h01, 0);
    issue({4'b1001, 2'd2, 2'd0}, 8'h00, 0);
    check_taps("R8 rejected while busy");
    wait_idle(WRC - 4);
    issue({4'b1011, 2'd2, 2'd0}, 8'h00, 1);

    issue({4'b1010, 2'd1, 2'd0}, 8'h7D, 1);
    issue({4'b0010, 2'd1, 2'd0}, 8'h00, 1);
    repeat (4) step(1'b1);
    check_taps("R9 step up saturates");
    chk("R9 flags kept", m_wcr[1], 8'h7F);
    repeat (2) step(1'b0);
    check_taps("R9 step down");
    issue({4'b1001, 2'd1, 2'd0}, 8'h00, 1);
    step(1'b1);
    check_taps("R9 mode ended");
    issue({4'b1010, 2'd0, 2'd0}, 8'h01, 1);
    issue({4'b0010, 2'd0, 2'd0}, 8'h00, 1);
    repeat (3) step(1'b0);
    check_taps("R9 step down saturates");

    issue({4'b0100, 2'd1, 2'd0}, 8'h3C, 1);
    chk("R10 err pulse", err, 1);
    check_taps("R10 no change");
    @(negedge clk);
    chk("R10 err one cycle", err, 0);
    issue({4'b1111, 2'd2, 2'd1}, 8'h00, 1);
    chk("R10 err pulse 1111", err, 1);
    issue({4'b0000, 2'd0, 2'd0}, 8'h00, 1);
    chk("R10 err pulse 0000", err, 1);
    issue({4'b1011, 2'd1, 2'd0}, 8'h00, 1);

    repeat (3) @(negedge clk);
    chk("R4 all reads returned", exp_q.size(), 0);
    finish_up();
  end
endmodule